// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog for a system controller. A prescaler turns the core clock into a slow tick (nominally 0.6 s per tick, set by a parameter that can be made small for simulation). A 10-bit down-counter steps down once per tick and starts from a programmable initial value. When the counter runs out the first time, it reloads itself and raises a first-timeout flag. If it runs out again while that flag is still set, a second-timeout flag is raised and a one-cycle reset request is issued, unless the hardware no-reboot inhibit input is high.

Software uses a small register port. Any write to the reload register restarts the countdown from the programmed value. A read of that register returns the live count. A halt bit in the control register stops counting. Status flags are cleared by writing ones to them. A boot-failure strobe input records a boot status flag. Registers are word-addressed. Reads are combinational from the address, and writes take effect on the rising clock edge where the write enable is high.

Top module: `wdt_twostage`

## Requirements
- R1: After reset, the halt bit is 1, the initial-value field is 4, the count is 4, all status flags are 0 and `reset_req` is 0.
- R2: While the halt bit (control register, address 2, bit 11) is 1, the count does not change. Writes to the control register affect only bit 11, and its other bits read as 0.
- R3: While running, the count decreases by one every `TICK_DIV` clock cycles. The first tick falls `TICK_DIV` cycles after the write that released the halt or restarted the countdown.
- R4: A write of any data to the reload register (address 0) loads the count with the initial-value field and restarts the prescaler.
- R5: A read of address 0 returns the count in bits [9:0] and zeros above.
- R6: The initial-value register (address 1) holds its field in bits [9:0]. A write whose field is 0 to 3 leaves the field unchanged. Bits [15:10] are always stored as written and read back. Writing this register does not change the count.
- R7: A tick that finds the count at 1 is an expiry. The count reloads from the field on that edge. If the first-timeout flag (address 3, bit 3) was clear, it is set.
- R8: An expiry while the first-timeout flag is set raises the second-timeout flag (address 4, bit 1) and, one edge later, holds `reset_req` high for exactly one cycle.
- R9: While `no_reboot` is 1, a second expiry still sets the second-timeout flag but produces no `reset_req`.
- R10: The status flags are write-one-to-clear. Writing 0 to a flag bit leaves it unchanged.
- R11: A cycle with `boot_fail` high sets the boot status flag (address 4, bit 2).
- R12: A reset request leaves the status flags set, and the counter keeps counting down from the reloaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| no_reboot | input | 1 | Hardware inhibit of the reset request |
| boot_fail | input | 1 | Sets the boot status flag |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A wrong count shows up on the very next read of address 0, because the count is read combinationally. A counter that drifts by one tick changes the value seen there within `TICK_DIV` cycles. A flag that sets on the wrong expiry, or one that fails to clear, moves the first `reset_req` pulse by a whole countdown period (initial value times `TICK_DIV` cycles). A missing inhibit or a stretched pulse is visible on `reset_req` one cycle after the second expiry. The checks are therefore timed to the exact edge of each tick and expiry, not only to the final state.

// File: rtl/wdt_pkg.sv
// Shared register map and bit positions of the two-stage watchdog.
// Assumes word addressing; bit positions are the ones software decodes.
package wdt_pkg;
    localparam int ADDR_W   = 3;
    localparam int HALT_BIT = 11;
    localparam int TMO1_BIT = 3;
    localparam int TMO2_BIT = 1;
    localparam int BOOT_BIT = 2;
    localparam int INIT_MIN = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_RELOAD = 3'd0,
        REG_INIT   = 3'd1,
        REG_CTRL   = 3'd2,
        REG_STAT1  = 3'd3,
        REG_STAT2  = 3'd4
    } wdt_reg_e;
endpackage

// File: rtl/wdt_prescaler.sv
// Divides the core clock into one-cycle ticks, one every TICK_DIV cycles.
// Assumes run and restart are registered controls; restart suppresses a tick.
module wdt_prescaler #(
    parameter int TICK_DIV = 60_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pcnt;

    // Tick fires on the last cycle of each division period.
    assign tick = run && !restart && (pcnt == LAST);

    // Division counter: cleared when stopped, restarted or wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_downcount.sv
// Tick-driven down-counter that reloads on expiry or on request.
// Assumes init_val never below the minimum, so the count never reaches 0.
module wdt_downcount #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    import wdt_pkg::*;

    // Expiry: a tick would take the count to zero.
    assign expire = tick && !reload && (cnt <= CNT_W'(1));

    // Count register: reload has priority, expiry reloads, tick decrements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(INIT_MIN);
        end else if (reload || expire) begin
            cnt <= init_val;
        end else if (tick) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_regfile.sv
// Software-visible registers, two-stage status flags and reset request.
// Assumes one access per cycle; a flag being set wins over a same-cycle clear.
module wdt_regfile #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [wdt_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic [CNT_W-1:0]          cnt,
    input  logic                      expire,
    input  logic                      no_reboot,
    input  logic                      boot_fail,
    output logic                      halt,
    output logic [CNT_W-1:0]          init_val,
    output logic                      reload_pulse,
    output logic                      flag1,
    output logic                      flag2,
    output logic                      reset_req
);
    import wdt_pkg::*;

    localparam int HI_W = DATA_W - CNT_W;

    logic [HI_W-1:0] init_hi;
    logic            boot_flag;
    logic            wr_init, wr_ctrl, wr_st1, wr_st2;
    logic            stage1, stage2;

    // Write decode per register.
    assign reload_pulse = wr_en && (addr == REG_RELOAD);
    assign wr_init      = wr_en && (addr == REG_INIT);
    assign wr_ctrl      = wr_en && (addr == REG_CTRL);
    assign wr_st1       = wr_en && (addr == REG_STAT1);
    assign wr_st2       = wr_en && (addr == REG_STAT2);

    // Expiry stages: first arms the flag, second escalates.
    assign stage1 = expire && !flag1;
    assign stage2 = expire && flag1;

    // Initial-value register: small codes leave the field alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_val <= CNT_W'(INIT_MIN);
            init_hi  <= '0;
        end else if (wr_init) begin
            init_hi <= wdata[DATA_W-1:CNT_W];
            if (wdata[CNT_W-1:0] >= CNT_W'(INIT_MIN)) begin
                init_val <= wdata[CNT_W-1:0];
            end
        end
    end

    // Control register: only the halt bit is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt <= 1'b1;
        end else if (wr_ctrl) begin
            halt <= wdata[HALT_BIT];
        end
    end

    // Status flags: set by events, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag1     <= 1'b0;
            flag2     <= 1'b0;
            boot_flag <= 1'b0;
        end else begin
            flag1     <= (flag1 && !(wr_st1 && wdata[TMO1_BIT])) || stage1;
            flag2     <= (flag2 && !(wr_st2 && wdata[TMO2_BIT])) || stage2;
            boot_flag <= (boot_flag && !(wr_st2 && wdata[BOOT_BIT])) || boot_fail;
        end
    end

    // Reset request: one-cycle pulse after a second expiry, unless inhibited.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
        end else begin
            reset_req <= stage2 && !no_reboot;
        end
    end

    // Read mux: live count, stored fields and flags.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_RELOAD: rdata[CNT_W-1:0] = cnt;
            REG_INIT:   rdata = {init_hi, init_val};
            REG_CTRL:   rdata[HALT_BIT] = halt;
            REG_STAT1:  rdata[TMO1_BIT] = flag1;
            REG_STAT2: begin
                rdata[TMO2_BIT] = flag2;
                rdata[BOOT_BIT] = boot_flag;
            end
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_twostage.sv
// Top of the two-stage watchdog: prescaler, down-counter and registers.
// Assumes a single synchronous clock domain for the bus and the timer.
module wdt_twostage #(
    parameter int TICK_DIV = 60_000_000,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [wdt_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic                       no_reboot,
    input  logic                       boot_fail,
    output logic                       reset_req
);
    logic             tick, expire, halt, reload_pulse, flag1, flag2;
    logic [CNT_W-1:0] cnt, init_val;

    wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(!halt), .restart(reload_pulse), .tick(tick)
    );

    wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_pulse),
        .init_val(init_val), .cnt(cnt), .expire(expire)
    );

    wdt_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt(cnt), .expire(expire), .no_reboot(no_reboot),
        .boot_fail(boot_fail), .halt(halt), .init_val(init_val),
        .reload_pulse(reload_pulse), .flag1(flag1), .flag2(flag2),
        .reset_req(reset_req)
    );
endmodule

// File: rtl/wdt_checker.sv
// Temporal properties of the two-stage watchdog, bound into the top.
// Assumes the internal names cnt, halt, init_val, flag1 and flag2 of the top.
module wdt_checker #(
    parameter int CNT_W = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [wdt_pkg::ADDR_W-1:0] addr,
    input logic                       no_reboot,
    input logic                       reset_req,
    input logic [CNT_W-1:0]           cnt,
    input logic                       halt,
    input logic [CNT_W-1:0]           init_val,
    input logic                       flag1,
    input logic                       flag2
);
    import wdt_pkg::*;

    // R2: halted and no reload write means the count holds.
    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !(wr_en && addr == REG_RELOAD)) |=> $stable(cnt));

    // R4: a reload write brings the count to the programmed value.
    p_reload_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_RELOAD) |=> (cnt == $past(init_val)));

    // R6: the field never holds an ignored code.
    p_init_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_val >= CNT_W'(INIT_MIN));

    // R3: the count never reaches zero.
    p_cnt_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '0);

    // R7: the first-timeout flag rises together with a reload of the count.
    p_first_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag1) |-> (cnt == $past(init_val)));

    // R8: the reset request lasts one cycle.
    p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R9: no request when the inhibit was high at the expiry.
    p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> !$past(no_reboot));

    // R12: the request comes with the second-timeout flag still set.
    p_req_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> flag2);
endmodule

bind wdt_twostage wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .no_reboot(no_reboot), .reset_req(reset_req), .cnt(cnt), .halt(halt),
    .init_val(init_val), .flag1(flag1), .flag2(flag2)
);

// File: tb/wdt_twostage_tb.sv
// Self-checking bench: a vector table, then directed expiry and reset tests.
module wdt_twostage_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WT = 2'd2;
    localparam int NV = 32;
    // {op, addr, data, expected}
    localparam logic [36:0] VEC [NV] = '{
        {OP_RD, 3'd0, 16'h0000, 16'h0004},  // R1 count
        {OP_RD, 3'd1, 16'h0000, 16'h0004},  // R1 init field
        {OP_RD, 3'd2, 16'h0000, 16'h0800},  // R1 halt
        {OP_RD, 3'd3, 16'h0000, 16'h0000},  // R1 stat1
        {OP_RD, 3'd4, 16'h0000, 16'h0000},  // R1 stat2
        {OP_WT, 3'd0, 16'd10,   16'h0000},
        {OP_RD, 3'd0, 16'h0000, 16'h0004},  // R2 halted holds
        {OP_WR, 3'd1, 16'h0402, 16'h0000},
        {OP_RD, 3'd1, 16'h0000, 16'h0404},  // R6 small code ignored, top kept
        {OP_WR, 3'd1, 16'h000A, 16'h0000},
        {OP_RD, 3'd1, 16'h0000, 16'h000A},  // R6 field written
        {OP_RD, 3'd0, 16'h0000, 16'h0004},  // R6 count untouched
        {OP_WR, 3'd0, 16'h0000, 16'h0000},
        {OP_RD, 3'd0, 16'h0000, 16'h000A},  // R4 R5 reload
        {OP_WR, 3'd2, 16'h0000, 16'h0000},
        {OP_WT, 3'd0, 16'd8,    16'h0000},
        {OP_RD, 3'd0, 16'h0000, 16'h0008},  // R3 two ticks
        {OP_WT, 3'd0, 16'd3,    16'h0000},
        {OP_RD, 3'd0, 16'h0000, 16'h0008},  // R3 not yet
        {OP_WT, 3'd0, 16'd1,    16'h0000},
        {OP_RD, 3'd0, 16'h0000, 16'h0007},  // R3 tick edge
        {OP_WR, 3'd0, 16'h1234, 16'h0000},
        {OP_WT, 3'd0, 16'd3,    16'h0000},
        {OP_RD, 3'd0, 16'h0000, 16'h000A},  // R4 prescaler restarted
        {OP_WT, 3'd0, 16'd1,    16'h0000},
        {OP_RD, 3'd0, 16'h0000, 16'h0009},  // R4 first tick after restart
        {OP_WR, 3'd2, 16'h0800, 16'h0000},
        {OP_WT, 3'd0, 16'd20,   16'h0000},
        {OP_RD, 3'd0, 16'h0000, 16'h0009},  // R2 halted again
        {OP_WR, 3'd2, 16'hFFFF, 16'h0000},
        {OP_RD, 3'd2, 16'h0000, 16'h0800},  // R2 only halt bit
        {OP_RD, 3'd0, 16'h0000, 16'h0009}   // R2 still held
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        no_reboot = 1'b0;
    logic        boot_fail = 1'b0;
    logic        reset_req;

    int n_chk = 0, n_err = 0, rr_seen = 0, rr_base;
    bit done = 1'b0;

    wdt_twostage #(.TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .no_reboot(no_reboot), .boot_fail(boot_fail),
        .reset_req(reset_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count cycles with the reset request high.
    always @(negedge clk) if (reset_req) rr_seen++;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic rdchk(input string tag, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset_req idle", {15'd0, reset_req}, 16'd0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][36:35])
                OP_WR: wr(VEC[i][34:32], VEC[i][31:16]);
                OP_RD: rdchk($sformatf("table row %0d", i), VEC[i][34:32], VEC[i][15:0]);
                default: wt(int'(VEC[i][31:16]));
            endcase
        end

        // R7 R8 R12: two expiries with init 4.
        wr(3'd1, 16'h0004);
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0000);
        rr_base = rr_seen;
        wt(15);
        rdchk("R3 count at 1", 3'd0, 16'd1);
        rdchk("R7 flag before expiry", 3'd3, 16'h0000);
        wt(1);
        rdchk("R7 reload on expiry", 3'd0, 16'd4);
        rdchk("R7 first flag set", 3'd3, 16'h0008);
        check("R7 no request on first", {15'd0, reset_req}, 16'd0);
        wt(15);
        check("R8 no early request", {15'd0, reset_req}, 16'd0);
        wt(1);
        check("R8 request high", {15'd0, reset_req}, 16'd1);
        rdchk("R8 second flag", 3'd4, 16'h0002);
        rdchk("R12 first flag kept", 3'd3, 16'h0008);
        wt(1);
        check("R8 request dropped", {15'd0, reset_req}, 16'd0);
        check("R8 single pulse", 16'(rr_seen - rr_base), 16'd1);
        wt(3);
        rdchk("R12 keeps counting", 3'd0, 16'd3);
        wr(3'd2, 16'h0800);

        // R10: write-one-to-clear.
        wr(3'd3, 16'h0000);
        rdchk("R10 zero write no effect", 3'd3, 16'h0008);
        wr(3'd4, 16'h0002);
        rdchk("R10 clear second flag", 3'd4, 16'h0000);
        wr(3'd3, 16'h0008);
        rdchk("R10 clear first flag", 3'd3, 16'h0000);

        // R9: inhibit blocks the request.
        no_reboot = 1'b1;
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0000);
        rr_base = rr_seen;
        wt(32);
        rdchk("R9 second flag still set", 3'd4, 16'h0002);
        wt(4);
        check("R9 no request", 16'(rr_seen - rr_base), 16'd0);
        wr(3'd2, 16'h0800);
        no_reboot = 1'b0;

        // R11: boot strobe.
        boot_fail = 1'b1;
        wt(1);
        boot_fail = 1'b0;
        rdchk("R11 boot flag set", 3'd4, 16'h0006);
        wr(3'd4, 16'h0004);
        rdchk("R10 clear boot only", 3'd4, 16'h0002);

        // R1: reset while running.
        wr(3'd1, 16'h0C09);
        wr(3'd2, 16'h0000);
        wt(5);
        rst_n = 1'b0;
        wt(2);
        rst_n = 1'b1;
        rdchk("R1 count after reset", 3'd0, 16'h0004);
        rdchk("R1 init after reset", 3'd1, 16'h0004);
        rdchk("R1 halt after reset", 3'd2, 16'h0800);
        rdchk("R1 stat1 after reset", 3'd3, 16'h0000);
        rdchk("R1 stat2 after reset", 3'd4, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R1..all watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule